// File: doc/BRIEF.md
# CDR Frequency Lock Supervisor

This block supervises a clock-and-data-recovery loop. It measures the frequency of the recovered oscillator against a reference clock. A binary counter runs in the oscillator domain and is published as a Gray code. A short synchronizer chain carries that code into the reference domain. At the end of each fixed window of reference cycles, the supervisor takes the difference between two successive samples. That difference is the number of oscillator cycles in the window, and it is compared with a tolerance band around the ratio expected for the selected line rate. Frequency lock is granted after two in-band windows in a row. One out-of-band window withdraws it.

The same block decodes the control pins. These are signal-detect, an active-low force-to-reference input, a test bypass and the rate select. From them it derives a loss-of-signal state, a steering output that makes the loop track the reference, an illegal-mode flag, and the select codes for the data and clock output multiplexers. The lock indicator is the frequency lock qualified by these controls. Every output is registered in the reference domain and follows a control change after one reference cycle.

Reset is synchronous and active high. It is applied in both clock domains and must be held for several cycles of each clock.

Top module: `cdr_lock_supervisor`

## Requirements
- R1: After reset the first window only primes the measurement. Lock rises only after two consecutive in-band windows follow it, and never after a single one.
- R2: A window whose count lies outside the band withdraws the lock, whether the oscillator runs fast or slow.
- R3: `lock_det` is 0 one cycle after `sig_det` is low, `lock_ref_n` is low or `bypass` is high, whatever the frequency measurement shows. When the control returns to normal, lock comes back on the next cycle if frequency lock is still held.
- R4: One cycle after the controls change, `los` and `track_ref` are both 1 when `bypass` is 0 and at least one of `sig_det` and `lock_ref_n` is 0. Otherwise both are 0.
- R5: During loss of signal, `data_sel` is 2'b00. This code drives the true data output low and the complementary output high.
- R6: With `bypass` 0 and `sig_det` and `lock_ref_n` both 1, `data_sel` is 2'b01 (retimed data) and `clk_sel` is 0 (loop clock).
- R7: With `bypass` and `rate_hi` both 1, `data_sel` is 2'b10 (raw input data), `clk_sel` is 1 (inverted reference clock), and `los` is 0.
- R8: With `bypass` 1 and `rate_hi` 0, `mode_err` is 1. In this mode `lock_det`, `los`, `track_ref` and `clk_sel` are 0 and `data_sel` is 2'b00.
- R9: The window is 256 reference cycles. With `rate_hi` 1, the band is 8192±4 oscillator cycles (ratio 32). With `rate_hi` 0, it is 2048±1 (ratio 8). An oscillator at the high-rate frequency never locks in low-rate mode.
- R10: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all outputs are registered on it |
| clk_osc | input | 1 | Recovered oscillator clock being measured |
| rst | input | 1 | Synchronous active-high reset, held in both domains |
| rate_hi | input | 1 | 1 = high line rate (ratio 32), 0 = low line rate (ratio 8) |
| bypass | input | 1 | Test bypass of the loop |
| sig_det | input | 1 | Signal detect from the optical receiver |
| lock_ref_n | input | 1 | Active-low force to track the reference |
| lock_det | output | 1 | Loop locked to the data stream |
| los | output | 1 | Loss-of-signal state |
| track_ref | output | 1 | Steers the loop to follow the reference clock |
| mode_err | output | 1 | Forbidden control combination |
| data_sel | output | 2 | Data mux: 00 hold low, 01 retimed, 10 raw input |
| clk_sel | output | 1 | Clock mux: 0 loop clock, 1 inverted reference |

## Verification
A wrong window counter, prime flag or streak bit shows only on `lock_det`, and only at a window boundary. It can therefore stay hidden for up to three windows (about 770 reference cycles). For that reason the bench samples lock both before and after the second in-band window. A corrupted synchronized count, or a wrong expected ratio, shows as lock missing at the nominal frequency or present at a wrong one within two windows. A decode fault shows on the select and status outputs one cycle after the controls change, and the randomized control sweep catches it at once.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;
  typedef enum logic [1:0] {
    DSEL_HOLD_LOW = 2'b00,
    DSEL_RETIMED  = 2'b01,
    DSEL_RAW      = 2'b10
  } dsel_e;

  typedef enum logic {
    CSEL_LOOP    = 1'b0,
    CSEL_REF_INV = 1'b1
  } csel_e;
endpackage

// File: rtl/cdr_osc_gray.sv
module cdr_osc_gray #(
  parameter int CNT_W = 16
) (
  input  logic             clk_osc,
  input  logic             rst,
  output logic [CNT_W-1:0] gray_q
);
  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_nx;

  assign bin_nx = bin_q + CNT_W'(1);

  always_ff @(posedge clk_osc) begin
    if (rst) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_q <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/cdr_gray_sync.sv
module cdr_gray_sync #(
  parameter int CNT_W  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] gray_in,
  output logic [CNT_W-1:0] bin_out
);
  logic [CNT_W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= gray_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  always_comb begin
    bin_out[CNT_W-1] = stage_q[STAGES-1][CNT_W-1];
    for (int b = CNT_W - 2; b >= 0; b--)
      bin_out[b] = bin_out[b+1] ^ stage_q[STAGES-1][b];
  end
endmodule

// File: rtl/cdr_freq_window.sv
module cdr_freq_window #(
  parameter int WIN_LOG2 = 8,
  parameter int CNT_W    = 16,
  parameter int RATIO_HI = 32,
  parameter int RATIO_LO = 8,
  parameter int TOL_HI   = 4,
  parameter int TOL_LO   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rate_hi,
  input  logic [CNT_W-1:0] osc_count,
  output logic             freq_lock
);
  localparam logic [CNT_W-1:0] EXP_HI = CNT_W'(RATIO_HI << WIN_LOG2);
  localparam logic [CNT_W-1:0] EXP_LO = CNT_W'(RATIO_LO << WIN_LOG2);
  localparam logic [CNT_W-1:0] MIN_HI = EXP_HI - CNT_W'(TOL_HI);
  localparam logic [CNT_W-1:0] MAX_HI = EXP_HI + CNT_W'(TOL_HI);
  localparam logic [CNT_W-1:0] MIN_LO = EXP_LO - CNT_W'(TOL_LO);
  localparam logic [CNT_W-1:0] MAX_LO = EXP_LO + CNT_W'(TOL_LO);

  logic [WIN_LOG2-1:0] win_cnt;
  logic                win_end;
  logic [CNT_W-1:0]    prev_cnt;
  logic [CNT_W-1:0]    delta;
  logic                in_band;
  logic                primed;
  logic                streak;

  assign win_end = &win_cnt;
  assign delta   = osc_count - prev_cnt;

  always_comb begin
    if (rate_hi) in_band = (delta >= MIN_HI) && (delta <= MAX_HI);
    else         in_band = (delta >= MIN_LO) && (delta <= MAX_LO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt   <= '0;
      prev_cnt  <= '0;
      primed    <= 1'b0;
      streak    <= 1'b0;
      freq_lock <= 1'b0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (win_end) begin
        prev_cnt <= osc_count;
        if (!primed) begin
          primed <= 1'b1;
        end else if (in_band) begin
          streak <= 1'b1;
          if (streak) freq_lock <= 1'b1;
        end else begin
          streak    <= 1'b0;
          freq_lock <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cdr_mode_decode.sv
module cdr_mode_decode
  import cdr_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bypass,
  input  logic       rate_hi,
  input  logic       sig_det,
  input  logic       lock_ref_n,
  input  logic       freq_lock,
  output logic       lock_det,
  output logic       los,
  output logic       track_ref,
  output logic       mode_err,
  output logic [1:0] data_sel,
  output logic       clk_sel
);
  logic  forbid, pass_raw, los_nx, normal;
  dsel_e dsel_nx;
  csel_e csel_nx;

  always_comb begin
    forbid   = bypass & ~rate_hi;
    pass_raw = bypass & rate_hi;
    los_nx   = ~bypass & ~(sig_det & lock_ref_n);
    normal   = ~bypass & sig_det & lock_ref_n;
    csel_nx  = pass_raw ? CSEL_REF_INV : CSEL_LOOP;
    if (forbid || los_nx) dsel_nx = DSEL_HOLD_LOW;
    else if (pass_raw)    dsel_nx = DSEL_RAW;
    else                  dsel_nx = DSEL_RETIMED;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_det  <= 1'b0;
      los       <= 1'b0;
      track_ref <= 1'b0;
      mode_err  <= 1'b0;
      data_sel  <= DSEL_HOLD_LOW;
      clk_sel   <= CSEL_LOOP;
    end else begin
      lock_det  <= freq_lock & normal;
      los       <= los_nx;
      track_ref <= los_nx;
      mode_err  <= forbid;
      data_sel  <= dsel_nx;
      clk_sel   <= csel_nx;
    end
  end
endmodule

// File: rtl/cdr_lock_supervisor.sv
module cdr_lock_supervisor #(
  parameter int WIN_LOG2    = 8,
  parameter int CNT_W       = 16,
  parameter int RATIO_HI    = 32,
  parameter int RATIO_LO    = 8,
  parameter int TOL_HI      = 4,
  parameter int TOL_LO      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_ref,
  input  logic       clk_osc,
  input  logic       rst,
  input  logic       rate_hi,
  input  logic       bypass,
  input  logic       sig_det,
  input  logic       lock_ref_n,
  output logic       lock_det,
  output logic       los,
  output logic       track_ref,
  output logic       mode_err,
  output logic [1:0] data_sel,
  output logic       clk_sel
);
  logic [CNT_W-1:0] osc_gray;
  logic [CNT_W-1:0] osc_bin_ref;
  logic             freq_lock;

  cdr_osc_gray #(.CNT_W(CNT_W)) u_gray (
    .clk_osc (clk_osc),
    .rst     (rst),
    .gray_q  (osc_gray)
  );

  cdr_gray_sync #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk_ref),
    .rst     (rst),
    .gray_in (osc_gray),
    .bin_out (osc_bin_ref)
  );

  cdr_freq_window #(
    .WIN_LOG2 (WIN_LOG2),
    .CNT_W    (CNT_W),
    .RATIO_HI (RATIO_HI),
    .RATIO_LO (RATIO_LO),
    .TOL_HI   (TOL_HI),
    .TOL_LO   (TOL_LO)
  ) u_win (
    .clk       (clk_ref),
    .rst       (rst),
    .rate_hi   (rate_hi),
    .osc_count (osc_bin_ref),
    .freq_lock (freq_lock)
  );

  cdr_mode_decode u_dec (
    .clk        (clk_ref),
    .rst        (rst),
    .bypass     (bypass),
    .rate_hi    (rate_hi),
    .sig_det    (sig_det),
    .lock_ref_n (lock_ref_n),
    .freq_lock  (freq_lock),
    .lock_det   (lock_det),
    .los        (los),
    .track_ref  (track_ref),
    .mode_err   (mode_err),
    .data_sel   (data_sel),
    .clk_sel    (clk_sel)
  );
endmodule

// File: rtl/cdr_lock_supervisor_chk.sv
module cdr_lock_supervisor_chk (
  input logic       clk_ref,
  input logic       rst,
  input logic       rate_hi,
  input logic       bypass,
  input logic       sig_det,
  input logic       lock_ref_n,
  input logic       lock_det,
  input logic       los,
  input logic       track_ref,
  input logic       mode_err,
  input logic [1:0] data_sel,
  input logic       clk_sel
);
  assert_gated_lock_R3: assert property (@(posedge clk_ref) disable iff (rst)
    (!sig_det || !lock_ref_n || bypass) |=> !lock_det);

  assert_los_set_R4: assert property (@(posedge clk_ref) disable iff (rst)
    (!bypass && (!sig_det || !lock_ref_n)) |=> (los && track_ref));

  assert_los_clear_R4: assert property (@(posedge clk_ref) disable iff (rst)
    (bypass || (sig_det && lock_ref_n)) |=> (!los && !track_ref));

  assert_los_holds_low_R5: assert property (@(posedge clk_ref) disable iff (rst)
    los |-> (data_sel == 2'b00));

  assert_raw_path_R7: assert property (@(posedge clk_ref) disable iff (rst)
    (bypass && rate_hi) |=> (clk_sel && data_sel == 2'b10));

  assert_forbidden_R8: assert property (@(posedge clk_ref) disable iff (rst)
    (bypass && !rate_hi) |=> (mode_err && !lock_det && !clk_sel && data_sel == 2'b00));

  assert_lock_rise_normal_R6: assert property (@(posedge clk_ref) disable iff (rst)
    $rose(lock_det) |-> (!mode_err && !los && !clk_sel && data_sel == 2'b01));
endmodule

bind cdr_lock_supervisor cdr_lock_supervisor_chk u_chk (
  .clk_ref    (clk_ref),
  .rst        (rst),
  .rate_hi    (rate_hi),
  .bypass     (bypass),
  .sig_det    (sig_det),
  .lock_ref_n (lock_ref_n),
  .lock_det   (lock_det),
  .los        (los),
  .track_ref  (track_ref),
  .mode_err   (mode_err),
  .data_sel   (data_sel),
  .clk_sel    (clk_sel)
);

// File: tb/test_cdr_lock_supervisor.sv
`timescale 1ps/1ps
module test_cdr_lock_supervisor;
  localparam int REF_PERIOD = 51200;
  localparam int HALF_HI    = 800;
  localparam int HALF_LO    = 3200;

  logic       clk_ref = 1'b0;
  logic       clk_osc = 1'b0;
  logic       rst = 1'b1;
  logic       rate_hi = 1'b1;
  logic       bypass = 1'b0;
  logic       sig_det = 1'b1;
  logic       lock_ref_n = 1'b1;
  logic       lock_det, los, track_ref, mode_err, clk_sel;
  logic [1:0] data_sel;
  int         osc_half = HALF_HI;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  cdr_lock_supervisor i_cdr_lock_supervisor (
    .clk_ref(clk_ref), .clk_osc(clk_osc), .rst(rst), .rate_hi(rate_hi),
    .bypass(bypass), .sig_det(sig_det), .lock_ref_n(lock_ref_n),
    .lock_det(lock_det), .los(los), .track_ref(track_ref),
    .mode_err(mode_err), .data_sel(data_sel), .clk_sel(clk_sel)
  );

  always #(REF_PERIOD/2) clk_ref = ~clk_ref;

  initial begin
    #123;
    forever #(osc_half) clk_osc = ~clk_osc;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  function automatic logic [1:0] exp_dsel(input logic b, input logic r, input logic s, input logic l);
    if (b && !r)  return 2'b00;
    if (b && r)   return 2'b10;
    if (!(s && l)) return 2'b00;
    return 2'b01;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    wait_ref(20000);
    errors++;
    checks++;
    $display("FAIL watchdog actual 1 expected 0");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1945);
    wait_ref(6);
    // R10: reset state
    chk("R10 lock", lock_det, 0);
    chk("R10 los", los, 0);
    chk("R10 mode_err", mode_err, 0);
    chk("R10 data_sel", data_sel, 0);
    chk("R10 clk_sel", clk_sel, 0);
    rst = 1'b0;

    // R1: no lock after a single in-band window, lock after two
    wait_ref(600);
    chk("R1 no lock after one window", lock_det, 0);
    chk("R6 data_sel normal", data_sel, 1);
    chk("R6 clk_sel normal", clk_sel, 0);
    wait_ref(300);
    chk("R1 lock after two windows", lock_det, 1);

    // R2: fast oscillator drops lock
    osc_half = HALF_HI - 1;
    wait_ref(600);
    chk("R2 fast drops lock", lock_det, 0);
    osc_half = HALF_HI;
    wait_ref(900);
    chk("R1 relock high rate", lock_det, 1);
    osc_half = HALF_HI + 1;
    wait_ref(600);
    chk("R2 slow drops lock", lock_det, 0);

    // R9: low rate ratio
    rate_hi = 1'b0;
    osc_half = HALF_LO;
    wait_ref(1000);
    chk("R9 low-rate lock", lock_det, 1);
    osc_half = HALF_HI;
    wait_ref(600);
    chk("R9 high freq rejected in low mode", lock_det, 0);
    osc_half = HALF_LO + 10;
    wait_ref(900);
    chk("R2 low-rate slow stays unlocked", lock_det, 0);
    osc_half = HALF_LO;
    wait_ref(1000);
    chk("R9 low-rate relock", lock_det, 1);

    // R3: gating while frequency lock holds
    sig_det = 1'b0;
    wait_ref(1);
    chk("R3 sig_det low gates lock", lock_det, 0);
    chk("R4 los on sig_det low", los, 1);
    chk("R5 hold low during los", data_sel, 0);
    sig_det = 1'b1;
    wait_ref(1);
    chk("R3 lock returns", lock_det, 1);
    lock_ref_n = 1'b0;
    wait_ref(1);
    chk("R3 lock_ref_n low gates lock", lock_det, 0);
    chk("R4 track_ref on lock_ref_n low", track_ref, 1);
    lock_ref_n = 1'b1;
    wait_ref(1);
    chk("R3 lock returns again", lock_det, 1);

    // R8: forbidden combination (rate low, bypass high)
    bypass = 1'b1;
    wait_ref(1);
    chk("R8 mode_err", mode_err, 1);
    chk("R8 lock low", lock_det, 0);
    chk("R8 data_sel", data_sel, 0);
    chk("R8 los low", los, 0);

    // R7: bypass with high rate
    rate_hi = 1'b1;
    wait_ref(1);
    chk("R7 data_sel raw", data_sel, 2);
    chk("R7 clk_sel inverted ref", clk_sel, 1);
    chk("R7 los low", los, 0);
    chk("R3 bypass gates lock", lock_det, 0);

    // random sweep of the control pins
    for (int i = 0; i < 48; i++) begin
      logic [3:0] v;
      logic b, r, s, l, los_e;
      v = 4'($urandom);
      b = v[0]; r = v[1]; s = v[2]; l = v[3];
      bypass = b; rate_hi = r; sig_det = s; lock_ref_n = l;
      wait_ref(1);
      los_e = !b && !(s && l);
      chk("R4 los", los, los_e);
      chk("R4 track_ref", track_ref, los_e);
      chk("R8 mode_err", mode_err, b && !r);
      chk("R5 R6 R7 data_sel", data_sel, exp_dsel(b, r, s, l));
      chk("R7 clk_sel", clk_sel, b && r);
      if (!(!b && s && l)) chk("R3 lock gated", lock_det, 0);
    end

    finish_run();
  end
endmodule